// File: doc/BRIEF.md
# Stack-Addressed Floating-Point Register File

This block holds eight opaque 80-bit values organised as a circular stack. Every access names an entry by its distance from the current top (st0 is the top, st7 the deepest), so a 3-bit top pointer maps each relative name to a physical slot. The pointer moves down by one on a push and up by one on a pop, and it wraps modulo the depth. No data moves between slots when the stack grows or shrinks.

One operation is issued per clock through a 4-bit operation code. It comes with a relative index and an 80-bit write word. The operations are push, copy an entry onto the top, pop, overwrite an entry, overwrite an entry and then pop, exchange the top with another entry, mark one entry empty, and empty the whole stack. Each physical slot carries a valid tag. A push into an occupied slot is reported as overflow. A pop or source read of an empty slot is reported as underflow. An operation that faults changes nothing.

Two combinational read ports return entries by relative index, and a tag vector shows which relative entries hold values. The block does no arithmetic. It only stores and moves words.

Top module: `fp_stack_regfile`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the first cycle after it, all tags read empty, the top is physical slot 0, and neither fault flag is high.
- R2: Operation code 1 (push) with st7 empty stores the write word as the new st0 and marks it valid. Every older entry st(i) becomes st(i+1).
- R3: Operation code 1 or 2 while st7 is valid raises overflow in that cycle, and the stack, tags and top pointer are left unchanged.
- R4: Operation code 3 (pop) with st0 valid makes st(i+1) the new st(i) and leaves st7 empty. With st0 empty it raises underflow and changes nothing.
- R5: Operation code 2 pushes a copy of the entry named by the index onto the top, with the same shift as a push.
- R6: Operation code 6 swaps st0 with the indexed entry. An index of 0 swaps st0 with st1.
- R7: Operation code 4 writes the write word into the indexed entry and marks it valid, without moving the top.
- R8: Operation code 5 writes the write word into the indexed entry and then pops, so the written word ends up as st(index-1). Underflow is raised if st0 is empty.
- R9: Operation code 7 marks the indexed entry empty and leaves the top and all other tags unchanged.
- R10: Operation code 8 empties every entry and returns the top to slot 0. Codes 0 and 9 to 15 change nothing.
- R11: Both read ports are combinational. A read of st1 in the same cycle as a push returns the value held before the push.
- R12: Operation code 2 with an empty source, and operation code 6 with st0 or the partner empty, raise underflow and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| idx_i | input | 3 | Relative index for the operation |
| wdata_i | input | 80 | Word to push or write |
| rd_a_idx_i | input | 3 | Relative index for read port A |
| rd_a_data_o | output | 80 | Read port A data |
| rd_b_idx_i | input | 3 | Relative index for read port B |
| rd_b_data_o | output | 80 | Read port B data |
| tag_o | output | 8 | Valid tag per relative entry, bit i for st(i) |
| overflow_o | output | 1 | Current operation would push onto an occupied slot |
| underflow_o | output | 1 | Current operation would pop or read an empty slot |

## Verification
The bench builds the block with its default depth of eight and 80-bit width. With a stack that shallow, eight pushes fill it and the ninth hits overflow. A full drain then walks the top pointer once around the ring and back through the wrap point. Because the width is 80 bits, each pushed word carries distinct patterns in the upper bits, so a word taken from the wrong slot or cut short in a swap, copy or write-and-pop shows up on the read ports.

// File: rtl/fp_stack_regfile.sv
`timescale 1ns/1ps
module fp_stack_regfile #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [3:0]       op_i,
  input  logic [PTR_W-1:0] idx_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [PTR_W-1:0] rd_a_idx_i,
  output logic [WIDTH-1:0] rd_a_data_o,
  input  logic [PTR_W-1:0] rd_b_idx_i,
  output logic [WIDTH-1:0] rd_b_data_o,
  output logic [DEPTH-1:0] tag_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  localparam logic [3:0] OP_PUSH  = 4'd1;
  localparam logic [3:0] OP_DUP   = 4'd2;
  localparam logic [3:0] OP_POP   = 4'd3;
  localparam logic [3:0] OP_WRITE = 4'd4;
  localparam logic [3:0] OP_WRPOP = 4'd5;
  localparam logic [3:0] OP_XCHG  = 4'd6;
  localparam logic [3:0] OP_FREE  = 4'd7;
  localparam logic [3:0] OP_INIT  = 4'd8;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0] tag_q;
  logic [PTR_W-1:0] top_q;
  logic [PTR_W-1:0] below, above, pa, xa, ra, rb;
  logic             fault;

  assign below = top_q - PTR_W'(1);
  assign above = top_q + PTR_W'(1);
  assign pa    = top_q + idx_i;
  assign xa    = top_q + ((idx_i == '0) ? PTR_W'(1) : idx_i);
  assign ra    = top_q + rd_a_idx_i;
  assign rb    = top_q + rd_b_idx_i;

  assign rd_a_data_o = mem_q[ra];
  assign rd_b_data_o = mem_q[rb];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tag
    logic [PTR_W-1:0] phys;
    assign phys     = top_q + PTR_W'(g);
    assign tag_o[g] = tag_q[phys];
  end

  assign overflow_o = ((op_i == OP_PUSH) || (op_i == OP_DUP)) && tag_q[below];

  always_comb begin
    case (op_i)
      OP_DUP:           underflow_o = !tag_q[pa];
      OP_POP, OP_WRPOP: underflow_o = !tag_q[top_q];
      OP_XCHG:          underflow_o = !tag_q[top_q] || !tag_q[xa];
      default:          underflow_o = 1'b0;
    endcase
  end

  assign fault = overflow_o || underflow_o;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      top_q <= '0;
      tag_q <= '0;
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else if (!fault) begin
      case (op_i)
        OP_PUSH: begin
          mem_q[below] <= wdata_i;
          tag_q[below] <= 1'b1;
          top_q        <= below;
        end
        OP_DUP: begin
          mem_q[below] <= mem_q[pa];
          tag_q[below] <= 1'b1;
          top_q        <= below;
        end
        OP_POP: begin
          tag_q[top_q] <= 1'b0;
          top_q        <= above;
        end
        OP_WRITE: begin
          mem_q[pa] <= wdata_i;
          tag_q[pa] <= 1'b1;
        end
        OP_WRPOP: begin
          mem_q[pa]    <= wdata_i;
          tag_q[pa]    <= 1'b1;
          tag_q[top_q] <= 1'b0;
          top_q        <= above;
        end
        OP_XCHG: begin
          mem_q[top_q] <= mem_q[xa];
          mem_q[xa]    <= mem_q[top_q];
        end
        OP_FREE: tag_q[pa] <= 1'b0;
        OP_INIT: begin
          tag_q <= '0;
          top_q <= '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fp_stack_regfile_chk.sv
`timescale 1ns/1ps
module fp_stack_regfile_chk #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       op,
  input logic [PTR_W-1:0] idx,
  input logic [DEPTH-1:0] tags,
  input logic [PTR_W-1:0] top,
  input logic             ovf,
  input logic             unf
);
  // R1
  p_reset_empty_r1: assert property (@(posedge clk) rst |=> (tags == '0) && (top == '0) && !ovf && !unf);

  // R2
  p_push_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd1 && !ovf) |=> tags[0] && (tags[DEPTH-1:1] == $past(tags[DEPTH-2:0])) && (top == PTR_W'($past(top) - 1)));

  // R3
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    ovf |=> $stable(tags) && $stable(top));
  p_overflow_cause_r3: assert property (@(posedge clk) disable iff (rst)
    ovf |-> tags[DEPTH-1] && (op == 4'd1 || op == 4'd2));

  // R4
  p_pop_shift_r4: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd3 && !unf) |=> !tags[DEPTH-1] && (tags[DEPTH-2:0] == $past(tags[DEPTH-1:1])));

  // R12
  p_underflow_hold_r12: assert property (@(posedge clk) disable iff (rst)
    unf |=> $stable(tags) && $stable(top));

  // R9
  p_free_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd7) |=> !tags[$past(idx)] && $stable(top));

  // R10
  p_init_empties_r10: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd8) |=> (tags == '0) && (top == '0));
endmodule

bind fp_stack_regfile fp_stack_regfile_chk #(.DEPTH(DEPTH)) u_chk (
  .clk (clk_i),
  .rst (rst_i),
  .op  (op_i),
  .idx (idx_i),
  .tags(tag_o),
  .top (top_q),
  .ovf (overflow_o),
  .unf (underflow_o)
);

// File: tb/fp_stack_regfile_tb_top.sv
`timescale 1ns/1ps
module fp_stack_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op = '0;
  logic [2:0]  idx = '0;
  logic [79:0] wdata = '0;
  logic [2:0]  rda = '0, rdb = '0;
  logic [79:0] rda_d, rdb_d;
  logic [7:0]  tags;
  logic        ovf, unf;

  always #2.5 clk = ~clk;

  fp_stack_regfile dut_i (
    .clk_i(clk), .rst_i(rst), .op_i(op), .idx_i(idx), .wdata_i(wdata),
    .rd_a_idx_i(rda), .rd_a_data_o(rda_d), .rd_b_idx_i(rdb), .rd_b_data_o(rdb_d),
    .tag_o(tags), .overflow_o(ovf), .underflow_o(unf));

  typedef struct {
    string      req;
    logic [2:0] a, b;
    logic [79:0] ad, bd;
    logic        av, bv;
    logic [7:0]  tg;
    logic        ovf, unf;
  } item_t;

  item_t sbq[$];
  int n_run = 0, n_fail = 0;
  logic [79:0] m_d [8];
  logic        m_v [8];
  bit          done = 0;

  function automatic logic [7:0] mtags();
    logic [7:0] t;
    for (int k = 0; k < 8; k++) t[k] = m_v[k];
    return t;
  endfunction

  function automatic logic [79:0] word(input int n);
    return {16'hC000 + 16'(n), 16'h5A00 + 16'(n), 16'h0F0F ^ 16'(n*3), 16'h1234 + 16'(n*7), 16'h8000 + 16'(n)};
  endfunction

  task automatic shift_in(input logic [79:0] v);
    for (int k = 7; k > 0; k--) begin m_d[k] = m_d[k-1]; m_v[k] = m_v[k-1]; end
    m_d[0] = v; m_v[0] = 1'b1;
  endtask

  task automatic shift_out();
    logic [79:0] t0;
    t0 = m_d[0];
    for (int k = 0; k < 7; k++) begin m_d[k] = m_d[k+1]; m_v[k] = m_v[k+1]; end
    m_d[7] = t0; m_v[7] = 1'b0;
  endtask

  task automatic step(input logic [3:0] o, input int i, input logic [79:0] d, input int a, input string req);
    item_t it;
    logic eo, eu;
    int j;
    logic [79:0] t;
    @(negedge clk);
    op = o; idx = 3'(i); wdata = d; rda = 3'(a); rdb = 3'(7 - a);
    j  = (i == 0) ? 1 : i;
    eo = (o == 4'd1 || o == 4'd2) && m_v[7];
    case (o)
      4'd2:       eu = !m_v[i];
      4'd3, 4'd5: eu = !m_v[0];
      4'd6:       eu = !m_v[0] || !m_v[j];
      default:    eu = 1'b0;
    endcase
    it.req = req; it.a = 3'(a); it.b = 3'(7 - a);
    it.ad = m_d[a]; it.av = m_v[a]; it.bd = m_d[7-a]; it.bv = m_v[7-a];
    it.tg = mtags(); it.ovf = eo; it.unf = eu;
    sbq.push_back(it);
    if (!eo && !eu) begin
      case (o)
        4'd1: shift_in(d);
        4'd2: shift_in(m_d[i]);
        4'd3: shift_out();
        4'd4: begin m_d[i] = d; m_v[i] = 1'b1; end
        4'd5: begin m_d[i] = d; m_v[i] = 1'b1; shift_out(); end
        4'd6: begin t = m_d[0]; m_d[0] = m_d[j]; m_d[j] = t; end
        4'd7: m_v[i] = 1'b0;
        4'd8: for (int k = 0; k < 8; k++) m_v[k] = 1'b0;
        default: ;
      endcase
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk); #1;
      while (sbq.size() > 0) begin
        it = sbq.pop_front();
        n_run++;
        if (tags !== it.tg || ovf !== it.ovf || unf !== it.unf ||
            (it.av && rda_d !== it.ad) || (it.bv && rdb_d !== it.bd)) begin
          n_fail++;
          $display("FAIL %s: tags=%h ovf=%b unf=%b a[%0d]=%h b[%0d]=%h | expected tags=%h ovf=%b unf=%b a=%h(v%b) b=%h(v%b)",
                   it.req, tags, ovf, unf, it.a, rda_d, it.b, rdb_d,
                   it.tg, it.ovf, it.unf, it.ad, it.av, it.bd, it.bv);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : driver
    for (int k = 0; k < 8; k++) begin m_d[k] = '0; m_v[k] = 1'b0; end
    repeat (3) @(posedge clk);
    step(4'd0, 0, '0, 0, "R1 reset state");
    @(negedge clk); rst = 1'b0;
    step(4'd0, 0, '0, 0, "R1 after reset");
    step(4'd3, 0, '0, 0, "R4 pop of empty stack");
    step(4'd1, 0, word(1), 0, "R2 push first");
    step(4'd1, 0, word(2), 1, "R2 push second");
    step(4'd1, 0, word(3), 1, "R11 push with same-cycle st1 read");
    step(4'd0, 0, '0, 0, "R2 order after pushes");
    step(4'd0, 0, '0, 2, "R2 deepest pushed entry");
    step(4'd6, 2, '0, 0, "R6 exchange st0 with st2");
    step(4'd0, 0, '0, 2, "R6 after exchange st2");
    step(4'd6, 0, '0, 1, "R6 exchange with default st1");
    step(4'd0, 0, '0, 0, "R6 after default exchange");
    step(4'd2, 2, '0, 2, "R5 copy st2 to top");
    step(4'd0, 0, '0, 0, "R5 copied value on top");
    step(4'd4, 1, word(10), 1, "R7 overwrite st1");
    step(4'd0, 0, '0, 1, "R7 st1 after write");
    step(4'd4, 5, word(11), 5, "R7 write into empty st5");
    step(4'd5, 2, word(12), 1, "R8 write st2 then pop");
    step(4'd0, 0, '0, 1, "R8 written word now st1");
    step(4'd7, 2, '0, 2, "R9 free st2");
    step(4'd0, 0, '0, 0, "R9 tags after free");
    step(4'd6, 2, '0, 0, "R12 exchange with empty partner");
    step(4'd2, 2, '0, 0, "R12 copy from empty entry");
    step(4'd8, 0, '0, 0, "R10 empty the stack");
    step(4'd0, 0, '0, 0, "R10 state after empty");
    step(4'd6, 1, '0, 0, "R12 exchange with empty top");
    for (int n = 0; n < 8; n++) step(4'd1, 0, word(20 + n), 1, "R2 fill stack");
    step(4'd0, 0, '0, 7, "R2 full stack bottom");
    step(4'd1, 0, word(99), 0, "R3 push onto full stack");
    step(4'd2, 3, '0, 3, "R3 copy onto full stack");
    step(4'd9, 3, word(98), 3, "R10 unused code has no effect");
    step(4'd15, 0, word(97), 0, "R10 unused code has no effect");
    for (int n = 0; n < 8; n++) step(4'd3, 0, '0, 0, "R4 drain stack");
    step(4'd3, 0, '0, 0, "R4 pop after drain");
    step(4'd1, 0, word(40), 0, "R2 push after wrap");
    step(4'd1, 0, word(41), 1, "R11 push after wrap with st1 read");
    step(4'd0, 0, '0, 1, "R2 order after wrap");
    step(4'd0, 0, '0, 0, "R1 settle");
    @(negedge clk); op = '0;
    #3;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule